// File: doc/BRIEF.md
# Audio capture DMA controller

This block takes audio samples from a capture front end, holds them in a small FIFO and writes them to a circular buffer in memory. Each write is one word on a request/acknowledge port, and the words are grouped into bursts. A burst starts when the FIFO fill level reaches a threshold that software sets. The address pointer runs from a base address up to base plus size, then wraps back to the base.

Software writes three registers: a control word, a base address and a buffer size. It sets the enable bit last. Clearing the enable bit drains the FIFO to memory and raises a flush-done flag, but the pointer is kept. Setting enable again therefore carries on where the stream stopped. Only a soft reset, issued through a bit of the control word, makes the next capture start again at the base address. All resets are synchronous to the clock.

Top module: `acap_dma`

## Requirements
- R1: With enable set and a threshold T (1 to DEPTH) in control bits [3:0], a burst of exactly T words is issued whenever no transfer is active and the FIFO holds at least T words. mem_last_o marks the final word of the burst.
- R2: The words of a burst go out in sample order, to consecutive word addresses starting at the current pointer. When the next address would equal base plus size, the pointer returns to base and wrap_o goes high. wrap_o stays high until a soft or hard reset.
- R3: When enable is cleared, every word still held is written as one final burst, which may be shorter than T. flush_done_o then rises. If the FIFO is empty, flush_done_o rises with no write. Setting enable again clears flush_done_o.
- R4: Clearing enable leaves the pointer unchanged. The next enable continues at the address after the last word written.
- R5: Writing the control word with bit 31 set is a soft reset. It empties the FIFO, clears enable and all three flags, and ends any transfer. Base, size and threshold are kept, and the next enable writes its first word at the base address.
- R6: A sample that arrives while enabled with DEPTH words held is dropped, and overrun_o goes high and stays high until a reset.
- R7: Samples presented while enable is clear are not stored and never reach memory.
- R8: rst_ni low at a rising clock edge clears all state, synchronously. mem_req_o and all flags then read zero.
- R9: Register map: address 0 is control (bit 30 enable, bit 31 soft reset, bits [3:0] threshold), address 1 is base (low AW bits) and address 2 is size in words.
- R10: Once mem_req_o is high, mem_addr_o and mem_data_o hold steady until mem_ack_i is high at a rising edge. One word moves on each edge where both mem_req_o and mem_ack_i are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_data_i | input | DW | Sample value |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Word address of current write |
| mem_data_o | output | DW | Data of current write |
| mem_last_o | output | 1 | Current word ends the burst |
| mem_ack_i | input | 1 | Memory accepts current word |
| overrun_o | output | 1 | Sticky sample-drop flag |
| wrap_o | output | 1 | Sticky buffer-wrap flag |
| flush_done_o | output | 1 | Flush after disable completed |

## Verification
Two functions can act in the same cycle: a burst request stalled by memory, and a sample arriving at a full FIFO. The bench holds acknowledge low once a full-depth burst is requested, then presents two more samples. These should be dropped while the request stays on the same address and data. After the stall is released, the bench checks that exactly the first DEPTH samples come out in order at consecutive addresses, and that overrun_o stays set. A sweep over every threshold also checks where a disable lands relative to burst boundaries. It compares the flush length with the remainder of the sample count divided by the threshold, and the address that follows re-enable with an arithmetic pointer model.

// File: rtl/acap_pkg.sv
package acap_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_BASE = 2'd1;
  localparam logic [1:0] REG_SIZE = 2'd2;
  localparam int CTRL_EN_BIT   = 30;
  localparam int CTRL_SRST_BIT = 31;

  typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_FLUSH} xfer_st_e;
endpackage

// File: rtl/acap_fifo.sv
module acap_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + PW'(1);
      if (pop_i)  rp_q <= rp_q + PW'(1);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: ;
      endcase
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/acap_addr_gen.sv
module acap_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrap_o
);
  logic [AW-1:0] ptr_q, nxt, lim;
  logic          loaded_q, wrap_q;

  assign nxt = ptr_q + AW'(1);
  assign lim = base_i + size_i;

  // pointer is taken from base only on the first enable after a reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) begin
      ptr_q    <= '0;
      loaded_q <= 1'b0;
      wrap_q   <= 1'b0;
    end else if (start_i && !loaded_q) begin
      ptr_q    <= base_i;
      loaded_q <= 1'b1;
    end else if (step_i) begin
      if (nxt == lim) begin
        ptr_q  <= base_i;
        wrap_q <= 1'b1;
      end else begin
        ptr_q  <= nxt;
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/acap_xfer_ctl.sv
module acap_xfer_ctl
  import acap_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cap_en_i,
  input  logic          en_rise_i,
  input  logic          en_fall_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] thr_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic          last_o,
  output logic          pop_o,
  output logic          flush_done_o
);
  xfer_st_e      st_q;
  logic [CW-1:0] rem_q;
  logic          pend_q, done_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cap_en_i && thr_i != '0 && count_i >= thr_i) begin
            st_q  <= ST_BURST;
            rem_q <= thr_i;
          end else if (pend_q && !cap_en_i) begin
            if (count_i == '0) begin
              done_q <= 1'b1;
              pend_q <= 1'b0;
            end else begin
              st_q  <= ST_FLUSH;
              rem_q <= count_i;   // flush length fixed at entry
            end
          end
        end
        default: begin
          if (ack_i) begin
            rem_q <= rem_q - CW'(1);
            if (rem_q == CW'(1)) begin
              st_q <= ST_IDLE;
              if (st_q == ST_FLUSH) begin
                done_q <= pend_q;
                pend_q <= 1'b0;
              end
            end
          end
        end
      endcase
      if (en_fall_i) pend_q <= 1'b1;
      if (en_rise_i) begin
        pend_q <= 1'b0;
        done_q <= 1'b0;
      end
    end
  end

  assign req_o        = (st_q != ST_IDLE);
  assign last_o       = req_o && (rem_q == CW'(1));
  assign pop_o        = req_o && ack_i;
  assign flush_done_o = done_q;
endmodule

// File: rtl/acap_dma.sv
module acap_dma
  import acap_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          mem_last_o,
  input  logic          mem_ack_i,
  output logic          overrun_o,
  output logic          wrap_o,
  output logic          flush_done_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          cap_en, ovr_q;
  logic [CW-1:0] thr_q, fifo_cnt;
  logic [AW-1:0] base_q, size_q;
  logic          ctrl_wr, srst, en_rise, en_fall;
  logic          fifo_full, push, pop;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  assign ctrl_wr = reg_we_i && (reg_addr_i == REG_CTRL);
  assign srst    = ctrl_wr && reg_wdata_i[CTRL_SRST_BIT];
  assign en_rise = ctrl_wr && !srst && reg_wdata_i[CTRL_EN_BIT] && !cap_en;
  assign en_fall = ctrl_wr && !srst && !reg_wdata_i[CTRL_EN_BIT] && cap_en;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cap_en <= 1'b0;
      thr_q  <= '0;
      base_q <= '0;
      size_q <= '0;
      ovr_q  <= 1'b0;
    end else if (srst) begin
      cap_en <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          REG_CTRL: begin
            cap_en <= reg_wdata_i[CTRL_EN_BIT];
            thr_q  <= reg_wdata_i[CW-1:0];
          end
          REG_BASE: base_q <= reg_wdata_i[AW-1:0];
          REG_SIZE: size_q <= reg_wdata_i[AW-1:0];
          default:  ;
        endcase
      end
      if (cap_en && smp_valid_i && fifo_full) ovr_q <= 1'b1;
    end
  end

  assign push = cap_en && smp_valid_i && !fifo_full;

  acap_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (smp_data_i),
    .rdata_o (mem_data_o),
    .count_o (fifo_cnt),
    .full_o  (fifo_full)
  );

  acap_addr_gen #(.AW(AW)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst),
    .start_i (en_rise),
    .step_i  (pop),
    .base_i  (base_q),
    .size_i  (size_q),
    .ptr_o   (mem_addr_o),
    .wrap_o  (wrap_o)
  );

  acap_xfer_ctl #(.CW(CW)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (srst),
    .cap_en_i     (cap_en),
    .en_rise_i    (en_rise),
    .en_fall_i    (en_fall),
    .count_i      (fifo_cnt),
    .thr_i        (thr_q),
    .ack_i        (mem_ack_i),
    .req_o        (mem_req_o),
    .last_o       (mem_last_o),
    .pop_o        (pop),
    .flush_done_o (flush_done_o)
  );

  assign overrun_o = ovr_q;
endmodule

// File: rtl/acap_dma_chk.sv
module acap_dma_chk #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          srst_i,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_data_o,
  input logic          overrun_o,
  input logic          wrap_o,
  input logic          flush_done_o,
  input logic          cap_en_i,
  input logic [CW-1:0] fifo_cnt_i
);
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !srst_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o));

  a_r6_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !srst_i |=> overrun_o);

  a_r2_wrap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && !srst_i |=> wrap_o);

  a_r3_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> !mem_req_o);

  a_r7_no_fill_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> fifo_cnt_i <= $past(fifo_cnt_i));

  a_r6_fifo_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CW'(DEPTH));
endmodule

bind acap_dma acap_dma_chk #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .srst_i       (srst),
  .mem_req_o    (mem_req_o),
  .mem_ack_i    (mem_ack_i),
  .mem_addr_o   (mem_addr_o),
  .mem_data_o   (mem_data_o),
  .overrun_o    (overrun_o),
  .wrap_o       (wrap_o),
  .flush_done_o (flush_done_o),
  .cap_en_i     (cap_en),
  .fifo_cnt_i   (fifo_cnt)
);

// File: tb/acap_dma_test.sv
module acap_dma_test;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int DEPTH = 8;
  localparam int SZ = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          mem_ack = 1'b0;
  logic          mem_req, mem_last, overrun, wrap, flush_done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  acap_dma #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_last_o(mem_last), .mem_ack_i(mem_ack), .overrun_o(overrun),
    .wrap_o(wrap), .flush_done_o(flush_done)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit hold = 0, fresh = 1, done = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] e_data;
  logic [DW-1:0] next_smp = 16'h0a00;
  int exp_ptr = 0, exp_base = 0, exp_size = SZ, exp_run = 0, run_len = 0, words = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // memory model: ack decided at falling edge, word taken at next rising edge
  always @(negedge clk) begin
    cyc++;
    if (mem_req && !hold && (cyc % 3 != 0)) begin
      mem_ack = 1'b1;
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected write", mem_data, 0);
      end else begin
        e_data = exp_q.pop_front();
        chk(mem_data == e_data, "R1 data order", mem_data, e_data);
      end
      chk(mem_addr == AW'(exp_ptr), "R2 address", mem_addr, exp_ptr);
      exp_ptr++;
      if (exp_ptr == exp_base + exp_size) exp_ptr = exp_base;
      run_len++;
      words++;
      if (mem_last) begin
        chk(run_len == exp_run, "R1 burst length", run_len, exp_run);
        run_len = 0;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cfg(input int base, input int size);
    wr(2'd1, 32'(base));
    wr(2'd2, 32'(size));
    exp_base = base;
    exp_size = size;
  endtask

  task automatic enable(input int thr);
    if (fresh) exp_ptr = exp_base;
    fresh = 0;
    wr(2'd0, (32'd1 << 30) | 32'(thr));
  endtask

  task automatic disable_cap(input int thr);
    wr(2'd0, 32'(thr));
  endtask

  task automatic soft_reset();
    wr(2'd0, 32'd1 << 31);
    exp_q.delete();
    run_len = 0;
    fresh = 1;
  endtask

  task automatic push(input bit keep);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = next_smp;
    if (keep) exp_q.push_back(next_smp);
    next_smp++;
    @(negedge clk);
    smp_valid = 1'b0;
    idle(2);
  endtask

  initial begin
    int w0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R8 reset state
    chk(mem_req == 0, "R8 reset req", mem_req, 0);
    chk({overrun, wrap, flush_done} == 3'b000, "R8 reset flags", {overrun, wrap, flush_done}, 0);

    for (int thr = 1; thr <= DEPTH; thr++) begin
      int k;
      k = 3 * thr + thr / 2;
      soft_reset();
      idle(1);
      chk({overrun, wrap, flush_done} == 3'b000, "R5 flags after soft reset",
          {overrun, wrap, flush_done}, 0);
      cfg(16'h100 + thr * 16'h40, SZ);
      exp_run = thr;
      enable(thr);
      w0 = words;
      for (int i = 0; i < k; i++) push(1);
      idle(40);
      chk(words - w0 == thr * (k / thr), "R1 R9 full bursts", words - w0, thr * (k / thr));
      exp_run = k % thr;
      disable_cap(thr);
      idle(30);
      chk(words - w0 == k, "R3 flush count", words - w0, k);
      chk(flush_done == 1, "R3 flush done", flush_done, 1);
      chk(wrap == (k >= SZ), "R2 wrap flag", wrap, k >= SZ);
      // resume without soft reset: pointer carries on
      exp_run = thr;
      enable(thr);
      idle(1);
      chk(flush_done == 0, "R3 done cleared on enable", flush_done, 0);
      for (int i = 0; i < thr; i++) push(1);
      idle(30);
      chk(words - w0 == k + thr, "R4 resume words", words - w0, k + thr);
      disable_cap(thr);
      idle(5);
    end

    // R6 overrun while a burst request is stalled
    soft_reset();
    cfg(16'h800, 32);
    hold = 1;
    exp_run = DEPTH;
    enable(DEPTH);
    w0 = words;
    for (int i = 0; i < DEPTH; i++) push(1);
    push(0);
    push(0);
    idle(2);
    chk(overrun == 1, "R6 overrun set", overrun, 1);
    chk(mem_req == 1 && mem_addr == 16'h800, "R10 request held", mem_addr, 16'h800);
    idle(5);
    chk(mem_req == 1 && mem_addr == 16'h800, "R10 request still held", mem_addr, 16'h800);
    hold = 0;
    idle(30);
    chk(words - w0 == DEPTH, "R6 kept words", words - w0, DEPTH);
    chk(overrun == 1, "R6 overrun sticky", overrun, 1);

    // R3 flush with empty FIFO
    disable_cap(DEPTH);
    idle(4);
    chk(flush_done == 1, "R3 empty flush done", flush_done, 1);
    chk(words - w0 == DEPTH, "R3 empty flush no write", words - w0, DEPTH);

    // R7 samples ignored while disabled
    for (int i = 0; i < 5; i++) push(0);
    idle(10);
    chk(words - w0 == DEPTH, "R7 no write while disabled", words - w0, DEPTH);
    chk(overrun == 1 && mem_req == 0, "R7 no request while disabled", mem_req, 0);
    exp_run = 2;
    enable(2);
    push(1);
    push(1);
    idle(20);
    chk(words - w0 == DEPTH + 2, "R7 only new samples", words - w0, DEPTH + 2);

    // R8 hard reset clears sticky flags
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    exp_q.delete();
    fresh = 1;
    idle(1);
    chk({overrun, wrap, flush_done, mem_req} == 4'b0000, "R8 hard reset",
        {overrun, wrap, flush_done, mem_req}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog: actual %0d cycles expected fewer than %0d", 200000, 200000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule